// File: doc/BRIEF.md
# Masked Parallel Priority Interrupt Controller

This block collects a small set of interrupt request lines, holds each request in a sticky pending register, and filters the pending bits through a programmable mask. A fixed-priority encoder then picks the surviving request with the lowest index. That choice feeds a status flop. A separate enable flop, written only by software, decides whether the status reaches the single interrupt line to the processor.

When the processor acknowledges, the block places a vector on its data output. The vector is all zeros except for the encoded source index in its lowest bits. At all other times the output is held at zero and its output-enable is low. A small write port lets software load the mask, set or clear the enable, and clear chosen pending bits once a source has been serviced. Pushing the return address and running the service routine belong to the processor.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending bits, the mask (all sources blocked), the enable and the status are all zero, so `irq_out`, `vec_oe` and `vec_out` are 0.
- R2: A pending bit stays set until a write with `wr_sel` = 2 carries a 1 in that bit position of `wr_data`. Such a write clears exactly those bits. If a request arrives in the same cycle as the clear of its bit, the request wins and the bit stays set.
- R3: A request held high for a single clock cycle sets its pending bit on that edge and is not lost.
- R4: A write with `wr_sel` = 0 loads `wr_data` into the mask, where bit i = 1 lets source i through. A source whose mask bit is 0 does not reach the encoder or the status flop.
- R5: A write with `wr_sel` = 1 loads `wr_data[0]` into the enable flop. Nothing else changes the enable.
- R6: On every edge the status flop loads 1 if any pending bit is also unmasked, and 0 otherwise. `irq_out` is 1 exactly when both the status flop and the enable flop are 1. For a single-cycle request with the mask and enable already open, `irq_out` rises after the second clock edge.
- R7: Among the unmasked pending sources, index 0 has the highest priority and index 3 the lowest. The vector is the winning index in bits [1:0], with all upper bits 0.
- R8: While `ack_in` is 1, `vec_oe` is 1 and `vec_out` shows the vector for the current pending and mask state in the same cycle. While `ack_in` is 0, `vec_oe` is 0 and `vec_out` is 0.
- R9: A write with `wr_sel` = 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | NUM_SRC | Interrupt request lines, index 0 has the highest priority |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 enable, 2 clear pending, 3 none |
| wr_data | input | NUM_SRC | Write data |
| ack_in | input | 1 | Interrupt acknowledge from the processor |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | VEC_W | Vector, valid while acknowledged, 0 otherwise |
| vec_oe | output | 1 | Output enable for `vec_out` |

## Verification
A pending bit that drops on its own, or a mask bit that loads wrongly, shows up on the next acknowledge as a wrong vector index. If the affected source is the only one pending, it also shows one edge later as a missing or spurious `irq_out`. A status flop that lags or leads by a cycle is visible right after any request, mask write or clear, because the interrupt line is compared against a reference on every cycle. An enable flop corrupted by a stray write shows at once on `irq_out`, while the vector path stays unchanged.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   typedef enum logic [1:0] {
      SEL_MASK   = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_CLEAR  = 2'd2,
      SEL_NONE   = 2'd3
   } wsel_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);
   // one sticky cell per source; a new request overrides a clear
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n)          pend_o[g] <= 1'b0;
         else if (req_i[g])   pend_o[g] <= 1'b1;
         else if (clr_i[g])   pend_o[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [NUM_SRC-1:0] wr_data,
   output logic [NUM_SRC-1:0] mask_o,
   output logic               ien_o,
   output logic [NUM_SRC-1:0] clr_o
);
   wsel_e sel;
   assign sel = wsel_e'(wr_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_o <= '0;
         ien_o  <= 1'b0;
      end else if (wr_en) begin
         case (sel)
            SEL_MASK:   mask_o <= wr_data;
            SEL_ENABLE: ien_o  <= wr_data[0];
            default:    ;
         endcase
      end
   end

   // clear strobes go straight to the pending cells
   always_comb begin
      clr_o = '0;
      if (wr_en && sel == SEL_CLEAR) clr_o = wr_data;
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_SRC = 4,
   parameter int CODE_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] act_i,
   output logic [CODE_W-1:0]  code_o,
   output logic               valid_o
);
   // scan from the lowest priority upward so the lowest index is written last
   always_comb begin
      code_o  = '0;
      valid_o = 1'b0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (act_i[i]) begin
            code_o  = CODE_W'(i);
            valid_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int NUM_SRC = 4,
   parameter int VEC_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_in,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [NUM_SRC-1:0] wr_data,
   input  logic               ack_in,
   output logic               irq_out,
   output logic [VEC_W-1:0]   vec_out,
   output logic               vec_oe
);
   localparam int CODE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int PAD_W  = VEC_W - CODE_W;

   if (NUM_SRC < 2) begin : g_bad_src
      $error("prio_irq_ctrl: NUM_SRC must be at least 2");
   end
   if (PAD_W < 1) begin : g_bad_vec
      $error("prio_irq_ctrl: VEC_W must exceed the code width");
   end

   logic [NUM_SRC-1:0] pend_q, mask_q, clr_s, live_s;
   logic               ien_q, ist_q, enc_valid;
   logic [CODE_W-1:0]  enc_code;

   irq_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .mask_o(mask_q), .ien_o(ien_q), .clr_o(clr_s)
   );

   irq_pend_reg #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .req_i(req_in), .clr_i(clr_s), .pend_o(pend_q)
   );

   assign live_s = pend_q & mask_q;

   irq_prio_enc #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_enc (
      .act_i(live_s), .code_o(enc_code), .valid_o(enc_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ist_q <= 1'b0;
      else        ist_q <= enc_valid;
   end

   assign irq_out = ien_q & ist_q;
   assign vec_oe  = ack_in;
   assign vec_out = ack_in ? {{PAD_W{1'b0}}, enc_code} : '0;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
   parameter int NUM_SRC = 4,
   parameter int VEC_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] req_in,
   input logic               wr_en,
   input logic [1:0]         wr_sel,
   input logic               ack_in,
   input logic               irq_out,
   input logic [VEC_W-1:0]   vec_out,
   input logic               vec_oe,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] mask
);
   localparam int CODE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   logic [NUM_SRC-1:0] live, below;
   logic [CODE_W-1:0]  code;
   assign live = pend & mask;
   assign code = vec_out[CODE_W-1:0];
   always_comb begin
      below = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (i < int'(code)) below[i] = live[i];
   end

   // R2
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == 2'd2) |=> ((~pend & $past(pend)) == '0));
   // R3
   req_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_in != '0) |=> ((pend & $past(req_in)) == $past(req_in)));
   // R6
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(live != '0));
   // R7
   vec_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_oe && live != '0) |-> (live[code] && below == '0));
   // R7
   vec_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe |-> (vec_out[VEC_W-1:CODE_W] == '0));
   // R8
   vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_in |-> (vec_out == '0 && !vec_oe));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en), .wr_sel(wr_sel),
   .ack_in(ack_in), .irq_out(irq_out), .vec_out(vec_out), .vec_oe(vec_oe),
   .pend(pend_q), .mask(mask_q)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
   localparam int N = 4;
   localparam int VW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req_in = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd0;
   logic [N-1:0]  wr_data = '0;
   logic          ack_in = 1'b0;
   logic          irq_out, vec_oe;
   logic [VW-1:0] vec_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   prio_irq_ctrl #(.NUM_SRC(N), .VEC_W(VW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ack_in(ack_in), .irq_out(irq_out), .vec_out(vec_out),
      .vec_oe(vec_oe)
   );

   // behavioural reference state
   bit m_pend[N];
   bit m_mask[N];
   bit m_ien, m_ist;

   function automatic int first_live();
      for (int i = 0; i < N; i++) if (m_pend[i] && m_mask[i]) return i;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_pend[i]) begin m_pend[i] = 0; m_mask[i] = 0; end
         m_ien = 0; m_ist = 0;
      end else begin
         m_ist = (first_live() >= 0);
         for (int i = 0; i < N; i++) begin
            if (req_in[i]) m_pend[i] = 1;
            else if (wr_en && wr_sel == 2'd2 && wr_data[i]) m_pend[i] = 0;
         end
         if (wr_en && wr_sel == 2'd0)
            for (int i = 0; i < N; i++) m_mask[i] = wr_data[i];
         if (wr_en && wr_sel == 2'd1) m_ien = wr_data[0];
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, just before the rising edge
   always @(negedge clk) begin
      #8;
      if (rst_n && !done) begin
         int w;
         w = first_live();
         chk("R6 irq_out", irq_out, (m_ien && m_ist) ? 1 : 0);
         chk("R8 vec_oe", vec_oe, ack_in ? 1 : 0);
         chk("R7 vec_out", vec_out, (ack_in && w > 0) ? w : 0);
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
      @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wr_req(input logic [1:0] sel, input logic [N-1:0] d, input logic [N-1:0] r);
      @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d; req_in = r;
      @(negedge clk); wr_en = 1'b0; req_in = '0;
   endtask

   task automatic pulse(input logic [N-1:0] r);
      @(negedge clk); req_in = r;
      @(negedge clk); req_in = '0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic peek(string tag, int exp);
      @(negedge clk); ack_in = 1'b1;
      #8;
      chk(tag, vec_out, exp);
      @(negedge clk); ack_in = 1'b0;
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      #8;
      chk("R1 irq_out", irq_out, 0);
      chk("R1 vec_oe", vec_oe, 0);
      chk("R1 vec_out", vec_out, 0);

      pulse(4'b0100);
      idle(2);
      #8 chk("R4 masked irq", irq_out, 0);
      peek("R4 masked vector", 0);

      wr(2'd0, 4'hF);
      wr(2'd1, 4'h1);
      idle(2);
      #8 chk("R3 captured pulse raises irq", irq_out, 1);
      peek("R7 single source vector", 2);

      pulse(4'b1001);
      peek("R7 lowest index wins", 0);

      wr(2'd0, 4'b1100);
      peek("R4 mask removes source 0", 2);

      wr(2'd2, 4'b0100);
      peek("R2 clear removes source 2", 3);

      wr(2'd3, 4'h0);
      peek("R9 ignored select keeps mask", 3);
      #8 chk("R9 ignored select keeps enable", irq_out, 1);

      wr(2'd1, 4'h0);
      #8 chk("R5 enable cleared drops irq", irq_out, 0);
      peek("R8 vector while acknowledged", 3);
      #8 chk("R8 idle vector zero", vec_out, 0);

      wr_req(2'd2, 4'hF, 4'b1000);
      peek("R2 request beats clear", 3);

      wr(2'd1, 4'h1);
      wr(2'd2, 4'hF);
      idle(2);
      #8 chk("R6 status falls after clear", irq_out, 0);

      // mixed traffic checked by the per-cycle model
      wr(2'd0, 4'b1011);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         req_in = N'((k * 7 + 3) % 16) & N'(((k % 3) == 0) ? 4'hF : 4'h0);
         ack_in = (k % 4) == 1;
         wr_en  = (k % 5) == 2;
         wr_sel = 2'((k / 5) % 4);
         wr_data = N'((k * 5 + 1) % 16);
      end
      @(negedge clk);
      req_in = '0; ack_in = 1'b0; wr_en = 1'b0;
      idle(3);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule